// File: doc/BRIEF.md
# Password-Gated Clock Register Bank

This block is the 32-bit register file in front of a clock manager. A single request port carries a valid flag, a write flag, a byte address and write data. Every write must hold a fixed key in its top byte, or the block drops it. When the key matches, the block clears the key byte and stores the remaining payload. Each request, read or write, gets a registered response one cycle later. A response to an illegal address carries an error flag.

The block owns five PLLs. Each PLL has a group of control words and one word that it shares with its output channels. One read-only status word is not stored. It is computed live from each PLL's power-down and analog-reset bits. When a write is accepted into a PLL's words, the block issues a one-cycle update strobe with that PLL's index. The strobe also says whether the channels must be refreshed as well, which happens when the shared word was written. Downstream clock logic uses the strobe to recompute that PLL.

Top module: `clkreg_bank`

## Requirements
- R1: After reset every stored word reads as zero, the response and strobe outputs are low, and the lock-status word reads 0x0000_1F00.
- R2: A write whose bits 31:24 differ from 0x5A changes no register and raises no update strobe.
- R3: An accepted write stores its data with bits 31:24 forced to zero.
- R4: Every request gets rsp_valid_o one cycle later. A legal read of a stored word returns its current contents in that response.
- R5: A read of the lock-status word (byte address 0x080) returns bit 8+p set for PLL p (p = 0..4) exactly when bit 16 of that PLL's first control word (byte 0x1000 + 32·p) is clear and bit 8 of its shared word (byte 0x100 + 4·p) is clear. All other bits read zero.
- R6: Writes to the lock-status word are ignored, so a later read still returns the live lock value.
- R7: A request whose address has bits 1:0 non-zero or is at or above 0x2000 returns rdata zero with rsp_err_o high for that one response, and stores nothing.
- R8: An accepted write to one of the six control words of PLL p (bytes 0x1000 + 32·p through +0x14) gives upd_valid_o high for one cycle in the next cycle, with upd_pll_o = p and upd_chan_o = 0.
- R9: An accepted write to the shared word of PLL p gives the same strobe with upd_chan_o = 1.
- R10: A write to any other word, including the control-group offsets 0x18 and 0x1C, raises no update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 32 | Write data, key in bits 31:24 |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | 32 | Read data (zero for writes and errors) |
| rsp_err_o | output | 1 | Misaligned or out-of-window request |
| upd_valid_o | output | 1 | One-cycle PLL update strobe |
| upd_pll_o | output | 3 | Index of the PLL to update |
| upd_chan_o | output | 1 | Channels of that PLL need update too |

## Verification
Directed sequences walk one PLL at a time through power-down and analog-reset settings. The lock bit is read after each step, which shows the lock word is computed from two different words per PLL and not from stored data. Keys that are wrong and keys that are right are written to the same word in turn, which separates a dropped write from a stored one and shows that the key byte is removed. Addresses just past each control group, just past the window, and with low bits set show where the strobe region and the legal window end. A long random mix of reads and writes over the interesting words then checks the read data, error flag and strobe against a bench model on every access.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int DATA_W      = 32;
  localparam int KEY_LSB     = 24;
  localparam int KEY_W       = 8;
  localparam logic [KEY_W-1:0] KEY_VAL = 8'h5A;
  // word indices of the register layout
  localparam int LOCK_WORD   = 'h020;
  localparam int SHARED_BASE = 'h040;
  localparam int CTRL_BASE   = 'h400;
  localparam int CTRL_STRIDE = 8;
  localparam int CTRL_SPAN   = 6;
  // control and shared bit positions
  localparam int PWRDN_BIT   = 16;
  localparam int ANARST_BIT  = 8;
  localparam int LOCK_LSB    = 8;

  function automatic logic [DATA_W-1:0] strip_key(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[KEY_LSB +: KEY_W] = '0;
    return r;
  endfunction
endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
  import clkreg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 'h2000,
  parameter int NUM_PLL   = 5,
  localparam int IDX_W    = $clog2(WIN_BYTES / 4),
  localparam int PLL_W    = $clog2(NUM_PLL)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              legal_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              is_lock_o,
  output logic              pll_hit_o,
  output logic [PLL_W-1:0]  pll_idx_o,
  output logic              chan_o
);
  int widx;

  assign idx_o     = addr_i[IDX_W+1:2];
  assign legal_o   = (addr_i[1:0] == 2'b00) && (int'(addr_i) < WIN_BYTES);
  assign widx      = int'(idx_o);
  assign is_lock_o = (widx == LOCK_WORD);

  always_comb begin
    pll_hit_o = 1'b0;
    pll_idx_o = '0;
    chan_o    = 1'b0;
    for (int p = 0; p < NUM_PLL; p++) begin
      if (widx == SHARED_BASE + p) begin
        pll_hit_o = 1'b1;
        pll_idx_o = PLL_W'(p);
        chan_o    = 1'b1;
      end else if (widx >= CTRL_BASE + p * CTRL_STRIDE &&
                   widx <  CTRL_BASE + p * CTRL_STRIDE + CTRL_SPAN) begin
        pll_hit_o = 1'b1;
        pll_idx_o = PLL_W'(p);
      end
    end
  end
endmodule

// File: rtl/clkreg_store.sv
module clkreg_store
  import clkreg_pkg::*;
#(
  parameter int WORDS   = 2048,
  parameter int NUM_PLL = 5,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_PLL-1:0][DATA_W-1:0]  pll_ctrl_o,
  output logic [NUM_PLL-1:0][DATA_W-1:0]  pll_shared_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= strip_key(wdata_i);
    end
  end

  assign rdata_o = mem_q[idx_i];

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_tap
    assign pll_ctrl_o[p]   = mem_q[CTRL_BASE + p * CTRL_STRIDE];
    assign pll_shared_o[p] = mem_q[SHARED_BASE + p];

    // R3
    key_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pll_ctrl_o[p][KEY_LSB +: KEY_W] == '0 && pll_shared_o[p][KEY_LSB +: KEY_W] == '0);

    // R2
    stable_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> ($stable(pll_ctrl_o[p]) && $stable(pll_shared_o[p])));
  end
endmodule

// File: rtl/clkreg_lock.sv
module clkreg_lock
  import clkreg_pkg::*;
#(
  parameter int NUM_PLL = 5
) (
  input  logic [NUM_PLL-1:0][DATA_W-1:0] pll_ctrl_i,
  input  logic [NUM_PLL-1:0][DATA_W-1:0] pll_shared_i,
  output logic [DATA_W-1:0]              lock_word_o
);
  logic [NUM_PLL-1:0] locked;

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_lk
    assign locked[p] = !pll_ctrl_i[p][PWRDN_BIT] && !pll_shared_i[p][ANARST_BIT];
  end

  always_comb begin
    lock_word_o = '0;
    lock_word_o[LOCK_LSB +: NUM_PLL] = locked;
  end
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
  import clkreg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 'h2000,
  parameter int NUM_PLL   = 5,
  localparam int WORDS    = WIN_BYTES / 4,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int PLL_W    = $clog2(NUM_PLL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              upd_valid_o,
  output logic [PLL_W-1:0]  upd_pll_o,
  output logic              upd_chan_o
);
  logic             legal, is_lock, pll_hit, chan_hit, key_ok, wr_acc, we;
  logic [IDX_W-1:0] idx;
  logic [PLL_W-1:0] pll_idx;
  logic [DATA_W-1:0] mem_rdata, lock_word, rd_word;
  logic [NUM_PLL-1:0][DATA_W-1:0] pll_ctrl, pll_shared;

  clkreg_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .NUM_PLL(NUM_PLL)) u_dec (
    .addr_i   (req_addr_i),
    .legal_o  (legal),
    .idx_o    (idx),
    .is_lock_o(is_lock),
    .pll_hit_o(pll_hit),
    .pll_idx_o(pll_idx),
    .chan_o   (chan_hit)
  );

  assign key_ok = (req_wdata_i[KEY_LSB +: KEY_W] == KEY_VAL);
  assign wr_acc = req_valid_i && req_write_i && legal && key_ok;
  assign we     = wr_acc && !is_lock;

  clkreg_store #(.WORDS(WORDS), .NUM_PLL(NUM_PLL)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we),
    .idx_i       (idx),
    .wdata_i     (req_wdata_i),
    .rdata_o     (mem_rdata),
    .pll_ctrl_o  (pll_ctrl),
    .pll_shared_o(pll_shared)
  );

  clkreg_lock #(.NUM_PLL(NUM_PLL)) u_lock (
    .pll_ctrl_i  (pll_ctrl),
    .pll_shared_i(pll_shared),
    .lock_word_o (lock_word)
  );

  assign rd_word = is_lock ? lock_word : mem_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      upd_valid_o <= 1'b0;
      upd_pll_o   <= '0;
      upd_chan_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && !legal;
      rsp_rdata_o <= (req_valid_i && !req_write_i && legal) ? rd_word : '0;
      upd_valid_o <= wr_acc && pll_hit;
      upd_pll_o   <= (wr_acc && pll_hit) ? pll_idx : '0;
      upd_chan_o  <= wr_acc && pll_hit && chan_hit;
    end
  end

  // R7
  err_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0));

  // R8
  upd_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(req_valid_i && req_write_i));

  // R9
  chan_needs_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_chan_o |-> upd_valid_o);

  // R8
  upd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (int'(upd_pll_o) < NUM_PLL));
endmodule

// File: tb/sim_clkreg_bank.sv
module sim_clkreg_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, upd_valid, upd_chan;
  logic [31:0] rsp_rdata;
  logic [2:0]  upd_pll;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] model [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkreg_bank u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .upd_valid_o(upd_valid), .upd_pll_o(upd_pll), .upd_chan_o(upd_chan)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_lock();
    logic [31:0] r = '0;
    for (int p = 0; p < 5; p++)
      r[8+p] = !model['h400 + 8*p][16] && !model['h40 + p][8];
    return r;
  endfunction

  task automatic xact(input bit wr, input logic [15:0] a, input logic [31:0] d);
    bit legal, key_ok, acc, is_lock, hit, chan;
    int idx, hp;
    logic [31:0] exp_rd;
    string rtag, utag;
    legal   = (a[1:0] == 2'b00) && (a < 16'h2000);
    idx     = int'(a[12:2]);
    key_ok  = (d[31:24] == 8'h5A);
    acc     = wr && legal && key_ok;
    is_lock = (idx == 'h20);
    hit = 1'b0; chan = 1'b0; hp = 0;
    for (int p = 0; p < 5; p++) begin
      if (idx == 'h40 + p) begin hit = 1'b1; chan = 1'b1; hp = p; end
      else if (idx >= 'h400 + 8*p && idx < 'h400 + 8*p + 6) begin hit = 1'b1; hp = p; end
    end
    if (!legal || wr) exp_rd = '0;
    else if (is_lock) exp_rd = exp_lock();
    else exp_rd = model[idx];
    rtag = !legal ? "R7" : (is_lock ? "R5" : "R4");
    utag = !wr ? "R4" : (!legal ? "R7" : (!key_ok ? "R2" : (is_lock ? "R6" :
           (!hit ? "R10" : (chan ? "R9" : "R8")))));
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 rsp_valid", 32'(rsp_valid), 32'd1);
    check("R7 rsp_err", 32'(rsp_err), 32'(!legal));
    check(rtag, rsp_rdata, exp_rd);
    check(utag, 32'(upd_valid), 32'(acc && hit));
    if (acc && hit) begin
      check(chan ? "R9 pll" : "R8 pll", 32'(upd_pll), 32'(hp));
      check(chan ? "R9 chan" : "R8 chan", 32'(upd_chan), 32'(chan));
    end
    if (acc && !is_lock) model[idx] = d & 32'h00FF_FFFF;
  endtask

  function automatic logic [15:0] pick_addr();
    int k = int'($urandom_range(0, 9));
    case (k)
      0:       return 16'h0080;
      1, 2:    return 16'(16'h0100 + 4 * $urandom_range(0, 4));
      3, 4, 5: return 16'(16'h1000 + 32 * $urandom_range(0, 4) + 4 * $urandom_range(0, 7));
      6:       return 16'({$urandom_range(0, 2047), 2'b00});
      7:       return 16'({$urandom_range(0, 2047), 2'b00}) | 16'($urandom_range(1, 3));
      8:       return 16'($urandom_range(16'h2000, 16'hFFFF));
      default: return 16'(16'h1000 + 32 * $urandom_range(0, 4));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 2048; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 outputs idle after reset
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 upd_valid", 32'(upd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", rsp_rdata, 32'd0);
    // R1 reset contents and lock word
    xact(1'b0, 16'h0080, '0);
    check("R1 lock", exp_lock(), 32'h0000_1F00);
    xact(1'b0, 16'h1040, '0);
    xact(1'b0, 16'h0104, '0);
    // R5 power-down on PLL 2, then analog reset on PLL 3
    xact(1'b1, 16'h1040, 32'h5A01_0000);
    xact(1'b0, 16'h0080, '0);
    xact(1'b1, 16'h010C, 32'h3300_0100);   // R2 wrong key dropped
    xact(1'b0, 16'h010C, '0);
    xact(1'b0, 16'h0080, '0);
    xact(1'b1, 16'h010C, 32'h5A00_0100);   // R9
    xact(1'b0, 16'h0080, '0);
    // R3 key stripped
    xact(1'b1, 16'h0200, 32'h5ADE_ADBE);
    xact(1'b0, 16'h0200, '0);
    // R6 lock word ignores writes
    xact(1'b1, 16'h0080, 32'h5A00_0000);
    xact(1'b0, 16'h0080, '0);
    // R8 last control word, R10 first non-control offset
    xact(1'b1, 16'h1094, 32'h5A12_3456);
    xact(1'b1, 16'h1098, 32'h5A12_3456);
    xact(1'b1, 16'h109C, 32'h5A12_3456);
    // R7 misaligned and out-of-window
    xact(1'b1, 16'h1002, 32'h5AFF_FFFF);
    xact(1'b0, 16'h2000, '0);
    xact(1'b0, 16'hFFFC, '0);
    xact(1'b0, 16'h1000, '0);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 9) < 6) d[31:24] = 8'h5A;
      xact(1'($urandom_range(0, 1)), pick_addr(), d);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule